// File: doc/BRIEF.md
# UART Baud Tick Generator

This block produces the timing ticks for a secondary serial port. A small control register holds a run enable and a two-bit prescaler select. The system clock is first divided by the selected prescaler. Each prescaler wrap then advances a 16-bit up-counter that reloads from an external reload value when it overflows. Every overflow emits a one-cycle receiver sample tick. Every sixteenth sample tick is also the baud tick.

The register is reached through one 8-bit port with a single select line. Software writes the run bit and the prescaler select there, and reads the register back through the same port. The reload value comes in on a separate 16-bit input. It is sampled while the generator is stopped and again at every overflow. Clearing the run bit halts both counters and clears them. After a restart, the first tick therefore arrives exactly one full period later.

With prescaler ratio D and reload value R, the sample period is D × (65536 − R) clock cycles. The baud period is sixteen times the sample period.

Top module: `baud_tick_gen`

## Requirements
- R1: Register bit 6 is the run enable. While it reads 0, neither `sample_tick` nor `baud_tick` is ever high, and all counters are held cleared.
- R2: Register bits 1:0 select the prescaler ratio D: 2'b00 gives 12, 2'b01 gives 4, 2'b10 gives 48 and 2'b11 gives 1. While running, successive `sample_tick` pulses are D × (65536 − R) cycles apart, where R is the `reload` value.
- R3: Bits 7 and 5:2 always read back as 0, whatever was written to them. While `reg_sel` is 1, `reg_rdata` is {1'b0, run, 4'b0000, select}. While `reg_sel` is 0, `reg_rdata` is 0x00. A write takes effect only when `reg_sel` and `reg_wr` are both 1.
- R4: After reset, the register reads 0x00: the generator is stopped and the select is divide-by-12.
- R5: A select change made while running takes effect at the next prescaler wrap. The sample interval in progress lies between the old and new periods. Every later interval equals the new period.
- R6: The write that sets the run bit is captured on clock edge E0. The first `sample_tick` is visible after the clock edge that comes D × (65536 − R) edges after E0. This holds even when the generator was stopped partway through a period.
- R7: `baud_tick` is high only in cycles where `sample_tick` is high, and it is high on every sixteenth sample tick. The first baud tick after start comes after 16 × D × (65536 − R) edges.
- R8: `reload` is sampled at every overflow. A new reload value applied while running sets the length of every period that starts after the next overflow.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_sel | input | 1 | Selects the control register for read and write |
| reg_wr | input | 1 | Write strobe, qualified by `reg_sel` |
| reg_wdata | input | 8 | Write data for the control register |
| reg_rdata | output | 8 | Read data; 0 when the register is not selected |
| reload | input | 16 | Reload value for the tick counter |
| sample_tick | output | 1 | One-cycle receiver sample tick (16 per bit) |
| baud_tick | output | 1 | One-cycle baud tick |

## Verification
The bench covers every prescaler code and measures the first tick after a start as well as the steady period. A design that decodes the select as a monotonic ladder, or that starts the prescaler at a stale count, shows a wrong first-tick count. The bench stops the generator in the middle of a period and restarts it. A design that keeps a partial count then delivers its first tick early. The bench also changes the select and the reload value while the generator runs. A design that switches the ratio mid-count, or that reads the reload value only at start, shows the wrong settled interval. Writing all ones to the register exposes reserved bits that fail to read back as zero.

// File: rtl/bgen_pkg.sv
package bgen_pkg;

    localparam int unsigned RUN_BIT = 6;

    typedef enum logic [1:0] {
        SEL_DIV12 = 2'b00,
        SEL_DIV4  = 2'b01,
        SEL_DIV48 = 2'b10,
        SEL_DIV1  = 2'b11
    } presel_e;

    typedef struct packed {
        logic    run;
        presel_e sel;
    } ctrl_t;

    function automatic int unsigned sel_to_div(presel_e s);
        case (s)
            SEL_DIV12: return 12;
            SEL_DIV4:  return 4;
            SEL_DIV48: return 48;
            default:   return 1;
        endcase
    endfunction

endpackage

// File: rtl/bgen_ctrl.sv
module bgen_ctrl
    import bgen_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       reg_sel,
    input  logic       reg_wr,
    input  logic [7:0] reg_wdata,
    output logic [7:0] reg_rdata,
    output ctrl_t      ctrl_q,
    output ctrl_t      ctrl_d
);

    always_comb begin
        ctrl_d = ctrl_q;
        if (reg_sel && reg_wr) begin
            ctrl_d.run = reg_wdata[RUN_BIT];
            ctrl_d.sel = presel_e'(reg_wdata[1:0]);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctrl_q <= '{run: 1'b0, sel: SEL_DIV12};
        else        ctrl_q <= ctrl_d;
    end

    always_comb begin
        reg_rdata = 8'h00;
        if (reg_sel) begin
            reg_rdata[RUN_BIT] = ctrl_q.run;
            reg_rdata[1:0]     = ctrl_q.sel;
        end
    end

    // reserved positions never carry data
    p_rsvd_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rdata & 8'hBC) == 8'h00);

    // an unselected write leaves the register untouched
    p_wr_qualified_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_sel && reg_wr) |=> $stable(ctrl_q));

endmodule

// File: rtl/bgen_presc.sv
module bgen_presc
    import bgen_pkg::*;
#(
    parameter int unsigned PW = 6
) (
    input  logic  clk,
    input  logic  rst_n,
    input  ctrl_t cur,
    input  ctrl_t nxt,
    output logic  en
);

    typedef struct packed {
        logic [PW-1:0] cnt;
        logic [PW-1:0] lim;
    } pst_t;

    pst_t st_q, st_d;
    logic wrap;

    always_comb begin
        st_d = st_q;
        wrap = cur.run && (st_q.cnt == st_q.lim);
        if (!cur.run || !nxt.run) begin
            st_d.cnt = '0;
            st_d.lim = PW'(sel_to_div(nxt.sel) - 1);
        end else if (wrap) begin
            st_d.cnt = '0;
            st_d.lim = PW'(sel_to_div(cur.sel) - 1);
        end else begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    assign en = wrap;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{cnt: '0, lim: PW'(11)};
        else        st_q <= st_d;
    end

    // the ratio only changes at a wrap while running
    p_lim_steady_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (cur.run && nxt.run && !wrap) |=> $stable(st_q.lim));

    p_cnt_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= st_q.lim);

endmodule

// File: rtl/bgen_reload.sv
module bgen_reload #(
    parameter int unsigned CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run_cur,
    input  logic          run_nxt,
    input  logic          en,
    input  logic [CW-1:0] reload,
    output logic          ovf
);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } rst_t;

    rst_t st_q, st_d;

    always_comb begin
        st_d = st_q;
        ovf  = run_cur && en && (st_q.cnt == {CW{1'b1}});
        if (!run_cur || !run_nxt) begin
            st_d.cnt = reload;
        end else if (en) begin
            st_d.cnt = ovf ? reload : st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{cnt: '0};
        else        st_q <= st_d;
    end

    // counter only moves on a prescaler enable while running
    p_hold_no_en_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (run_cur && run_nxt && !en) |=> $stable(st_q.cnt));

endmodule

// File: rtl/bgen_ovs.sv
module bgen_ovs #(
    parameter int unsigned OVS = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_cur,
    input  logic run_nxt,
    input  logic step,
    output logic hit
);

    localparam int unsigned SW = $clog2(OVS);

    typedef struct packed {
        logic [SW-1:0] sub;
    } ost_t;

    ost_t st_q, st_d;

    always_comb begin
        st_d = st_q;
        hit  = run_cur && step && (st_q.sub == SW'(OVS - 1));
        if (!run_cur || !run_nxt) begin
            st_d.sub = '0;
        end else if (step) begin
            st_d.sub = hit ? '0 : st_q.sub + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{sub: '0};
        else        st_q <= st_d;
    end

    p_sub_clear_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !run_nxt |=> (st_q.sub == '0));

endmodule

// File: rtl/baud_tick_gen.sv
module baud_tick_gen
    import bgen_pkg::*;
#(
    parameter int unsigned CW  = 16,
    parameter int unsigned OVS = 16,
    parameter int unsigned PW  = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          reg_sel,
    input  logic          reg_wr,
    input  logic [7:0]    reg_wdata,
    output logic [7:0]    reg_rdata,
    input  logic [CW-1:0] reload,
    output logic          sample_tick,
    output logic          baud_tick
);

    typedef struct packed {
        logic sample;
        logic baud;
    } tick_t;

    ctrl_t ctrl_q, ctrl_d;
    logic  pre_en, ovf, hit;
    tick_t tk_q, tk_d;

    bgen_ctrl u_ctrl (
        .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .reg_wr(reg_wr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .ctrl_q(ctrl_q), .ctrl_d(ctrl_d)
    );

    bgen_presc #(.PW(PW)) u_presc (
        .clk(clk), .rst_n(rst_n), .cur(ctrl_q), .nxt(ctrl_d), .en(pre_en)
    );

    bgen_reload #(.CW(CW)) u_reload (
        .clk(clk), .rst_n(rst_n), .run_cur(ctrl_q.run), .run_nxt(ctrl_d.run),
        .en(pre_en), .reload(reload), .ovf(ovf)
    );

    bgen_ovs #(.OVS(OVS)) u_ovs (
        .clk(clk), .rst_n(rst_n), .run_cur(ctrl_q.run), .run_nxt(ctrl_d.run),
        .step(ovf), .hit(hit)
    );

    always_comb begin
        tk_d        = '0;
        tk_d.sample = ovf && ctrl_d.run;
        tk_d.baud   = hit && ctrl_d.run;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tk_q <= '0;
        else        tk_q <= tk_d;
    end

    assign sample_tick = tk_q.sample;
    assign baud_tick   = tk_q.baud;

    p_halt_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl_q.run |-> (!sample_tick && !baud_tick));

    p_baud_on_sample_r7: assert property (@(posedge clk) disable iff (!rst_n)
        baud_tick |-> sample_tick);

endmodule

// File: tb/sim_baud_tick_gen.sv
`timescale 1ns/1ps
module sim_baud_tick_gen;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_sel = 1'b0;
    logic        reg_wr = 1'b0;
    logic [7:0]  reg_wdata = 8'h00;
    logic [7:0]  reg_rdata;
    logic [15:0] reload = 16'hFFFC;
    logic        sample_tick, baud_tick;

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    always #2 clk = ~clk;

    baud_tick_gen u0 (
        .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .reg_wr(reg_wr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .reload(reload),
        .sample_tick(sample_tick), .baud_tick(baud_tick)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic wr_reg(input logic [7:0] v);
        @(negedge clk);
        reg_sel = 1'b1; reg_wr = 1'b1; reg_wdata = v;
        @(posedge clk);
        #1 reg_wr = 1'b0; reg_sel = 1'b0;
    endtask

    task automatic rd_reg(output logic [7:0] v);
        @(negedge clk);
        reg_sel = 1'b1;
        #1 v = reg_rdata;
        reg_sel = 1'b0;
    endtask

    // edges until sample_tick is seen, counted from the last edge
    task automatic wait_sample(output int n);
        n = 0;
        do begin
            @(posedge clk); n++; #1;
        end while (!sample_tick && n < 5000);
    endtask

    task automatic wait_baud(output int n);
        n = 0;
        do begin
            @(posedge clk); n++; #1;
        end while (!baud_tick && n < 20000);
    endtask

    function automatic int div_of(input int s);
        case (s)
            0: return 12;
            1: return 4;
            2: return 48;
            default: return 1;
        endcase
    endfunction

    task automatic t_reset();
        logic [7:0] v;
        int seen = 0;
        rd_reg(v);
        chk("R4", "reset readback", v, 8'h00);
        for (int i = 0; i < 60; i++) begin
            @(posedge clk); #1;
            if (sample_tick || baud_tick) seen++;
        end
        chk("R4", "ticks after reset", seen, 0);
    endtask

    task automatic t_regs();
        logic [7:0] v;
        wr_reg(8'hBC);
        rd_reg(v);
        chk("R3", "reserved bits read", v, 8'h00);
        wr_reg(8'h02);
        #1 chk("R3", "rdata unselected", reg_rdata, 8'h00);
        @(negedge clk);
        reg_wr = 1'b1; reg_wdata = 8'h41; reg_sel = 1'b0;
        @(posedge clk); #1 reg_wr = 1'b0;
        rd_reg(v);
        chk("R3", "unselected write ignored", v, 8'h02);
        wr_reg(8'hFF);
        rd_reg(v);
        chk("R3", "all-ones readback", v, 8'h43);
        wr_reg(8'h00);
    endtask

    task automatic t_divs();
        int n;
        reload = 16'hFFFC;
        for (int s = 0; s < 4; s++) begin
            wr_reg(8'h00);
            wr_reg(8'h40 | 8'(s));
            wait_sample(n);
            chk("R6", $sformatf("first tick sel %0d", s), n, 4 * div_of(s));
            wait_sample(n);
            chk("R2", $sformatf("period sel %0d", s), n, 4 * div_of(s));
        end
        wr_reg(8'h00);
    endtask

    task automatic t_baud();
        int n, cnt;
        reload = 16'hFFFE;
        wr_reg(8'h43);
        wait_baud(n);
        chk("R7", "first baud", n, 32);
        cnt = 0;
        n = 0;
        do begin
            @(posedge clk); n++; #1;
            if (sample_tick) cnt++;
        end while (!baud_tick && n < 2000);
        chk("R7", "baud interval", n, 32);
        chk("R7", "samples per baud", cnt, 16);
        wr_reg(8'h00);
    endtask

    task automatic t_stop();
        int n, seen;
        logic [7:0] v;
        reload = 16'hFFF0;
        wr_reg(8'h43);
        wait_sample(n);
        repeat (5) @(posedge clk);
        wr_reg(8'h03);
        seen = 0;
        for (int i = 0; i < 200; i++) begin
            @(posedge clk); #1;
            if (sample_tick || baud_tick) seen++;
        end
        chk("R1", "ticks while halted", seen, 0);
        rd_reg(v);
        chk("R1", "halted readback", v, 8'h03);
        wr_reg(8'h43);
        wait_sample(n);
        chk("R6", "first tick after mid-period stop", n, 16);
        wr_reg(8'h00);
    endtask

    task automatic t_selchg();
        int n;
        reload = 16'hFFFC;
        wr_reg(8'h40);
        wait_sample(n);
        repeat (7) @(posedge clk);
        wr_reg(8'h41);
        wait_sample(n);
        checks++;
        if (n < 1 || n > 48) begin
            errors++;
            $display("FAIL R5 mixed interval: actual %0d expected at most 48", n);
        end
        wait_sample(n);
        chk("R5", "settled period after select change", n, 16);
        wr_reg(8'h00);
    endtask

    task automatic t_reload();
        int n;
        reload = 16'hFFF0;
        wr_reg(8'h43);
        wait_sample(n);
        wait_sample(n);
        chk("R8", "period before reload change", n, 16);
        @(negedge clk) reload = 16'hFFF8;
        wait_sample(n);
        wait_sample(n);
        chk("R8", "period after reload change", n, 8);
        wr_reg(8'h00);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        t_reset();
        t_regs();
        t_divs();
        t_baud();
        t_stop();
        t_selchg();
        t_reload();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule